// File: doc/BRIEF.md
# Duty-cycled receiver listen sequencer

This block schedules a low-power receive front end so that it spends most of its time fully powered down. It opens short listening windows at a fixed rate. All of its timing is counted in pulses of a slow 1 kHz tick, which is delivered as a one-cycle strobe on the system clock. Two 4-bit codes set the timing. One sets how many ticks a listening window lasts. The other sets how many ticks separate the starts of consecutive windows. The amplifier is powered for a short settling interval before every window. That interval is taken from the end of the powered-down phase, so the window itself keeps its full length.

While a window is open, the carrier detector is enabled. When the detector reports a qualified carrier, the sequencer leaves the listening window and enters the data phase. In the data phase it enables the fast decode oscillator and keeps the amplifier output stage powered. The host is not woken by the carrier. It is woken only when the decoder reports that a message is active and that a byte is ready. That wake request is a level, and it stays high until the host reads the byte. When the message ends or is aborted, the sequencer returns to the powered-down phase and waits for the next scheduled window.

Top module: `lf_listen_seq`

## Requirements
- R1: During and directly after a synchronous reset, amp_en, det_en, osc_en and wake_req are all low.
- R2: While en is low, all four outputs are low one cycle later and stay low, whatever the other inputs do.
- R3: Every listening window is preceded by exactly 2 ticks in which amp_en is high and det_en is low. The first window after en rises is preceded in the same way: en rising starts this settling phase one cycle later.
- R4: A listening window (det_en and amp_en high) lasts on_code+1 ticks when no carrier arrives.
- R5: Consecutive window starts are (per_code+1)*4 ticks apart when that is at least on_code+3.
- R6: When (per_code+1)*4 is less than on_code+3, consecutive window starts are on_code+3 ticks apart.
- R7: Outside the settling phase, the listening window and the data phase, all outputs except wake_req are low.
- R8: A high carrier_det sampled while det_en is high makes osc_en and amp_en high and det_en low one cycle later. A carrier_det that arrives while det_en is low has no effect.
- R9: wake_req rises one cycle after a cycle in which osc_en, msg_active and byte_valid are all high. It does not rise for byte_valid without msg_active, and it does not rise outside the data phase.
- R10: wake_req stays high until byte_read is sampled high, and falls one cycle later. When msg_end is sampled in the data phase, all enables go low one cycle later, and the next window starts only after the following scheduled settling phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable of the receive path |
| tick_1k | input | 1 | One-cycle strobe at the 1 kHz slow rate |
| on_code | input | 4 | Listening window length code, window = code+1 ticks |
| per_code | input | 4 | Window period code, period = (code+1)*4 ticks |
| carrier_det | input | 1 | Qualified carrier reported by the detector |
| msg_active | input | 1 | Decoder reports a valid message in progress |
| byte_valid | input | 1 | Decoder reports a byte ready |
| byte_read | input | 1 | Host reads the byte, clears the wake request |
| msg_end | input | 1 | Message finished or aborted |
| amp_en | output | 1 | Amplifier power enable |
| det_en | output | 1 | Carrier detector enable (listening window) |
| osc_en | output | 1 | Fast decode oscillator enable (data phase) |
| wake_req | output | 1 | Host wake request level |

## Verification
Every output is a register. Each response therefore appears one system-clock cycle after the edge that samples the causing input: a tick that ends a phase, en, carrier_det, the byte_valid and msg_active pair, byte_read or msg_end. The bench changes inputs on the falling edge, and its reference model steps on the rising edge, so both see the same sampled values. The outputs are compared with the model on the following falling edge, which is the first point where the new register values are settled. The window lengths and periods are measured in ticks between rising edges of det_en. This covers both the stretched period and the plain period.

// File: rtl/lfl_pkg.sv
package lfl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_OFF    = 3'd1,
    ST_SETTLE = 3'd2,
    ST_LISTEN = 3'd3,
    ST_DATA   = 3'd4
  } lfl_state_t;
endpackage

// File: rtl/lfl_timing.sv
module lfl_timing #(
  parameter int CODE_W       = 4,
  parameter int PER_SCALE    = 4,
  parameter int SETTLE_TICKS = 2,
  parameter int POS_W        = 7
) (
  input  logic [CODE_W-1:0] on_code,
  input  logic [CODE_W-1:0] per_code,
  output logic [POS_W-1:0]  win_len,
  output logic [POS_W-1:0]  per_len
);
  localparam logic [POS_W-1:0] SCALE  = POS_W'(PER_SCALE);
  localparam logic [POS_W-1:0] SETTLE = POS_W'(SETTLE_TICKS);
  localparam logic [POS_W-1:0] ONE    = POS_W'(1);

  logic [POS_W-1:0] per_raw;
  logic [POS_W-1:0] per_min;

  always_comb begin
    win_len = POS_W'(on_code) + ONE;
    per_raw = (POS_W'(per_code) + ONE) * SCALE;
    per_min = win_len + SETTLE;
    per_len = (per_raw < per_min) ? per_min : per_raw;
  end
endmodule

// File: rtl/lfl_fsm.sv
module lfl_fsm
  import lfl_pkg::*;
#(
  parameter int SETTLE_TICKS = 2,
  parameter int POS_W        = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             carrier_det,
  input  logic             msg_end,
  input  logic [POS_W-1:0] win_len,
  input  logic [POS_W-1:0] per_len,
  output logic             amp_en,
  output logic             det_en,
  output logic             osc_en
);
  localparam logic [POS_W-1:0] SETTLE = POS_W'(SETTLE_TICKS);
  localparam logic [POS_W-1:0] ONE    = POS_W'(1);

  lfl_state_t       state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d, pos_adv, settle_at;

  always_comb begin
    settle_at = per_len - SETTLE;
    if (!tick)                    pos_adv = pos_q;
    else if (pos_q >= per_len - ONE) pos_adv = '0;
    else                          pos_adv = pos_q + ONE;
  end

  always_comb begin
    state_d = state_q;
    pos_d   = pos_adv;
    unique case (state_q)
      ST_IDLE: begin
        state_d = ST_SETTLE;
        pos_d   = settle_at;
      end
      ST_OFF:
        if (tick && pos_adv == settle_at) state_d = ST_SETTLE;
      ST_SETTLE:
        if (tick && pos_adv == '0) state_d = ST_LISTEN;
      ST_LISTEN:
        if (carrier_det)
          state_d = ST_DATA;
        else if (tick && pos_adv == win_len)
          state_d = (win_len == settle_at) ? ST_SETTLE : ST_OFF;
      ST_DATA:
        if (msg_end) state_d = ST_OFF;
      default: state_d = ST_IDLE;
    endcase
    if (!en) begin
      state_d = ST_IDLE;
      pos_d   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      amp_en  <= 1'b0;
      det_en  <= 1'b0;
      osc_en  <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      amp_en  <= (state_d == ST_SETTLE) || (state_d == ST_LISTEN) || (state_d == ST_DATA);
      det_en  <= (state_d == ST_LISTEN);
      osc_en  <= (state_d == ST_DATA);
    end
  end
endmodule

// File: rtl/lfl_wake.sv
module lfl_wake (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic in_data,
  input  logic msg_active,
  input  logic byte_valid,
  input  logic byte_read,
  output logic wake_req
);
  always_ff @(posedge clk) begin
    if (rst || !en)                            wake_req <= 1'b0;
    else if (in_data && msg_active && byte_valid) wake_req <= 1'b1;
    else if (byte_read)                        wake_req <= 1'b0;
  end
endmodule

// File: rtl/lf_listen_seq.sv
module lf_listen_seq #(
  parameter int CODE_W       = 4,
  parameter int PER_SCALE    = 4,
  parameter int SETTLE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick_1k,
  input  logic [CODE_W-1:0] on_code,
  input  logic [CODE_W-1:0] per_code,
  input  logic              carrier_det,
  input  logic              msg_active,
  input  logic              byte_valid,
  input  logic              byte_read,
  input  logic              msg_end,
  output logic              amp_en,
  output logic              det_en,
  output logic              osc_en,
  output logic              wake_req
);
  localparam int MAX_SPAN = (2**CODE_W) * PER_SCALE + (2**CODE_W) + SETTLE_TICKS + 1;
  localparam int POS_W    = $clog2(MAX_SPAN);

  logic [POS_W-1:0] win_len, per_len;

  lfl_timing #(
    .CODE_W(CODE_W), .PER_SCALE(PER_SCALE),
    .SETTLE_TICKS(SETTLE_TICKS), .POS_W(POS_W)
  ) u_timing (
    .on_code(on_code), .per_code(per_code),
    .win_len(win_len), .per_len(per_len)
  );

  lfl_fsm #(.SETTLE_TICKS(SETTLE_TICKS), .POS_W(POS_W)) u_fsm (
    .clk(clk), .rst(rst), .en(en), .tick(tick_1k),
    .carrier_det(carrier_det), .msg_end(msg_end),
    .win_len(win_len), .per_len(per_len),
    .amp_en(amp_en), .det_en(det_en), .osc_en(osc_en)
  );

  lfl_wake u_wake (
    .clk(clk), .rst(rst), .en(en), .in_data(osc_en),
    .msg_active(msg_active), .byte_valid(byte_valid),
    .byte_read(byte_read), .wake_req(wake_req)
  );
endmodule

// File: rtl/lfl_listen_chk.sv
module lfl_listen_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              tick_1k,
  input logic [CODE_W-1:0] on_code,
  input logic              carrier_det,
  input logic              msg_active,
  input logic              byte_valid,
  input logic              byte_read,
  input logic              amp_en,
  input logic              det_en,
  input logic              osc_en,
  input logic              wake_req
);
  logic [CODE_W+1:0] win_ticks;

  always_ff @(posedge clk) begin
    if (rst || !det_en)  win_ticks <= '0;
    else if (tick_1k)    win_ticks <= win_ticks + 1'b1;
  end

  a_r2_idle_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!amp_en && !det_en && !osc_en && !wake_req));

  a_r3_listen_after_settle: assert property (@(posedge clk) disable iff (rst)
    $rose(det_en) |-> $past(amp_en && !det_en));

  a_r4_window_ticks: assert property (@(posedge clk) disable iff (rst)
    ($fell(det_en) && !osc_en && $past(en)) |->
      (win_ticks == (CODE_W+2)'(on_code) + 1'b1));

  a_r8_osc_from_carrier: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en) |-> $past(det_en && carrier_det));

  a_r9_wake_source: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_req) |-> $past(osc_en && msg_active && byte_valid));

  a_r10_wake_hold: assert property (@(posedge clk) disable iff (rst)
    (wake_req && !byte_read && en) |=> wake_req);
endmodule

bind lf_listen_seq lfl_listen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .tick_1k(tick_1k), .on_code(on_code),
  .carrier_det(carrier_det), .msg_active(msg_active), .byte_valid(byte_valid),
  .byte_read(byte_read), .amp_en(amp_en), .det_en(det_en),
  .osc_en(osc_en), .wake_req(wake_req)
);

// File: tb/lf_listen_seq_bench.sv
module lf_listen_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, tick_1k = 1'b0;
  logic [3:0] on_code = 4'd0, per_code = 4'd0;
  logic carrier_det = 1'b0, msg_active = 1'b0, byte_valid = 1'b0;
  logic byte_read = 1'b0, msg_end = 1'b0;
  logic amp_en, det_en, osc_en, wake_req;

  int total = 0, bad = 0, cycles = 0;
  int m_st = 0, m_pos = 0;          // 0 idle 1 off 2 settle 3 listen 4 data
  bit m_wake = 0;
  int tick_cnt = 0, div = 0, last_rise = -1, last_period = -1, rises = 0;
  bit prev_det = 0, tick_run = 1'b1, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lf_listen_seq u_lf_listen_seq (
    .clk(clk), .rst(rst), .en(en), .tick_1k(tick_1k), .on_code(on_code),
    .per_code(per_code), .carrier_det(carrier_det), .msg_active(msg_active),
    .byte_valid(byte_valid), .byte_read(byte_read), .msg_end(msg_end),
    .amp_en(amp_en), .det_en(det_en), .osc_en(osc_en), .wake_req(wake_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    int span, win, nxt;
    bit was_data;
    was_data = (m_st == 4);
    if (rst || !en) begin
      m_st = 0; m_pos = 0; m_wake = 0;
    end else begin
      win  = on_code + 1;
      span = (per_code + 1) * 4;
      if (span < win + 2) span = win + 2;
      nxt = m_pos;
      if (tick_1k) nxt = (m_pos >= span - 1) ? 0 : m_pos + 1;
      if (was_data && msg_active && byte_valid) m_wake = 1;
      else if (byte_read) m_wake = 0;
      m_pos = nxt;
      if (m_st == 0) begin
        m_st = 2; m_pos = span - 2;
      end else if (m_st == 1) begin
        if (tick_1k && nxt == span - 2) m_st = 2;
      end else if (m_st == 2) begin
        if (tick_1k && nxt == 0) m_st = 3;
      end else if (m_st == 3) begin
        if (carrier_det) m_st = 4;
        else if (tick_1k && nxt == win) m_st = (win == span - 2) ? 2 : 1;
      end else begin
        if (msg_end) m_st = 1;
      end
    end
  end

  // per-cycle compare, period monitor, tick source
  always @(negedge clk) begin
    string tag;
    if (!done) begin
      cycles++;
      case (m_st)
        0: tag = rst ? "R1" : "R2";
        1: tag = "R7";
        2: tag = "R3";
        3: tag = "R4";
        default: tag = "R8";
      endcase
      chk(amp_en == (m_st == 2 || m_st == 3 || m_st == 4), {tag, " amp_en"}, amp_en, (m_st >= 2));
      chk(det_en == (m_st == 3), {tag, " det_en"}, det_en, (m_st == 3));
      chk(osc_en == (m_st == 4), {tag, " osc_en"}, osc_en, (m_st == 4));
      chk(wake_req == m_wake, m_wake ? "R9 wake_req" : "R10 wake_req", wake_req, m_wake);
      if (!en) begin
        last_rise = -1; last_period = -1; rises = 0;
      end else if (det_en && !prev_det) begin
        if (last_rise >= 0) last_period = tick_cnt - last_rise;
        last_rise = tick_cnt;
        rises++;
      end
      prev_det = det_en;
      if (tick_run && div == TICK_DIV - 1) begin
        div = 0; tick_1k = 1'b1; tick_cnt++;
      end else begin
        div = (div + 1) % TICK_DIV; tick_1k = 1'b0;
      end
      if (cycles >= WATCHDOG) begin
        done = 1;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rises(input int n);
    while (rises < n) @(negedge clk);
  endtask

  task automatic run_period(input int onc, input int perc, input int exp, input string tag);
    en = 1'b0; cyc(3);
    on_code = 4'(onc); per_code = 4'(perc);
    en = 1'b1;
    wait_rises(3);
    chk(last_period == exp, {tag, " period"}, last_period, exp);
  endtask

  initial begin
    cyc(3);
    chk(!amp_en && !det_en && !osc_en && !wake_req, "R1 reset", amp_en, 0);
    rst = 1'b0;
    carrier_det = 1'b1; byte_valid = 1'b1; msg_active = 1'b1;
    cyc(20);
    chk(!amp_en && !osc_en && !wake_req, "R2 disabled", osc_en, 0);
    carrier_det = 1'b0; byte_valid = 1'b0; msg_active = 1'b0;

    run_period(2, 3, 16, "R5");
    cyc(40);
    run_period(9, 1, 12, "R6");
    run_period(0, 0, 4, "R5");
    run_period(13, 2, 16, "R6");

    // carrier hand-off and wake handling
    en = 1'b0; cyc(3);
    on_code = 4'd3; per_code = 4'd2; en = 1'b1;
    wait_rises(1);
    carrier_det = 1'b1; @(negedge clk); carrier_det = 1'b0;
    chk(osc_en && !det_en && amp_en, "R8 handoff", osc_en, 1);
    byte_valid = 1'b1; @(negedge clk); byte_valid = 1'b0;
    chk(!wake_req, "R9 no msg_active", wake_req, 0);
    msg_active = 1'b1; byte_valid = 1'b1; @(negedge clk); byte_valid = 1'b0;
    chk(wake_req, "R9 wake", wake_req, 1);
    cyc(6);
    chk(wake_req, "R10 hold", wake_req, 1);
    byte_read = 1'b1; @(negedge clk); byte_read = 1'b0;
    chk(!wake_req, "R10 read clears", wake_req, 1'b0);
    msg_end = 1'b1; @(negedge clk); msg_end = 1'b0; msg_active = 1'b0;
    chk(!osc_en && !amp_en && !det_en, "R10 end to off", amp_en, 0);
    carrier_det = 1'b1; msg_active = 1'b1; byte_valid = 1'b1;
    @(negedge clk);
    carrier_det = 1'b0; msg_active = 1'b0; byte_valid = 1'b0;
    @(negedge clk);
    chk(!osc_en && !wake_req, "R8 carrier ignored off", osc_en, 0);
    wait_rises(3);
    chk(det_en && !osc_en, "R10 next window", det_en, 1);
    cyc(30);
    en = 1'b0; @(negedge clk);
    chk(!amp_en && !det_en && !osc_en, "R2 disable mid-run", amp_en, 0);
    cyc(5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule